// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Status Flags

This block performs one two-operand integer operation per clock at either byte or word width, and it produces the six status flags that a classic 16-bit microprocessor keeps after each operation. The eight two-operand operations are addition, addition with carry, subtraction, subtraction with borrow, comparison, and the bitwise OR, AND and XOR. A separate select can replace these with a unary increment or decrement of the destination. The caller supplies both operands, a width bit, the operation code, the unary select and the current carry flag.

The caller receives the result, a write-enable that tells the register file whether the result should be kept, and new values for the carry, auxiliary-carry, overflow, sign, zero and parity flags. The datapath is combinational and ends in one register stage, so every output reflects the inputs applied one clock earlier. Operand fetch, address generation and flag storage are the surrounding pipeline's job.

Top module: `flag_alu`

## Requirements
- R1: With the unary select low, the 3-bit operation code selects the result modulo the active width: 0 add, 1 OR, 2 add with carry, 3 subtract with borrow, 4 AND, 5 subtract, 6 XOR, 7 compare (which gives the difference). The outputs show the inputs of the previous rising edge.
- R2: When the width bit is 1 the block works on 16 bits. When it is 0, only bits 7..0 of both operands are used, every flag is taken at 8 bits, and result bits 15..8 are driven to zero.
- R3: Carry out is set for add when the true sum exceeds the width, and for subtract and compare when the source is larger than the destination. For add with carry and subtract with borrow, the incoming carry is included, so a source of all ones together with a carry-in of 1 sets carry out.
- R4: The auxiliary flag is bit 4 of source XOR destination XOR result for the arithmetic, increment and decrement operations (the source counts as 1 for increment and decrement). It is 0 for OR, AND and XOR.
- R5: For arithmetic operations the overflow flag equals carry out XOR the top bit of source XOR destination XOR result, and it is 0 whenever the result equals the destination. This matches signed two's-complement overflow.
- R6: OR, AND and XOR force both carry out and overflow to 0.
- R7: Write-enable is 0 for compare and 1 for every other operation, including increment and decrement.
- R8: When the unary select is 1, the operation code is ignored. Decrement is chosen when the decrement bit is 1, otherwise increment. The destination is stepped by one, and carry out repeats the incoming carry unchanged. Overflow is set when increment yields the most negative value, or when decrement starts from it (0x80 at byte width, 0x8000 at word width).
- R9: The sign flag is the top bit of the result at the active width. The zero flag is set when the result is zero at that width. The parity flag is 1 when result bits 7..0 hold an even number of ones.
- R10: While reset is asserted, the result, write-enable and all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| wide_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| op_i | input | 3 | Two-operand operation code |
| step_en_i | input | 1 | Selects the unary increment or decrement in place of op_i |
| step_dec_i | input | 1 | With step_en_i high: 1 decrement, 0 increment |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 16 | Registered result |
| wr_en_o | output | 1 | Registered result write-enable |
| cf_o | output | 1 | Carry flag |
| af_o | output | 1 | Auxiliary carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |

## Verification
The registered properties compare each output with the inputs of the previous edge. They therefore assume that every input is driven to a known value on every cycle after reset and is held steady across the sampling edge. The stimulus meets this by changing all inputs together on the falling clock edge, one complete vector per cycle. In narrow mode, the upper operand bytes carry deliberately nonzero patterns, so the zeroed upper result byte is really exercised. The unary vectors carry arbitrary operation codes, so that the ignored code is also seen to have no effect.

// File: rtl/afu_pkg.sv
package afu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_OR  = 3'd1,
        OP_ADC = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_SUB = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } afu_op_e;

    typedef enum logic [2:0] {
        FM_ADD   = 3'd0,
        FM_SUB   = 3'd1,
        FM_LOGIC = 3'd2,
        FM_INC   = 3'd3,
        FM_DEC   = 3'd4
    } afu_fmode_e;

    typedef struct packed {
        logic cf;
        logic af;
        logic of;
        logic sf;
        logic zf;
        logic pf;
    } afu_flags_t;

endpackage

// File: rtl/afu_addsub.sv
module afu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;
    logic         c_eff;

    always_comb begin
        // subtraction: a - b - cin == a + ~b + ~cin (mod 2^W)
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        sum   = a + b_eff + {{(W-1){1'b0}}, c_eff};
    end
endmodule

// File: rtl/afu_logic.sv
module afu_logic
    import afu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  afu_op_e      op,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            default: res = a ^ b;
        endcase
    end
endmodule

// File: rtl/afu_parity.sv
module afu_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic         even
);
    logic [W:0] chain;

    assign chain[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign chain[i+1] = chain[i] ^ vec[i];
    end
    assign even = chain[W];
endmodule

// File: rtl/afu_flag_gen.sv
module afu_flag_gen
    import afu_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NARROW_W   = 8,
    parameter int NIBBLE_BIT = 4
) (
    input  logic [DATA_W-1:0] dst_m,
    input  logic [DATA_W-1:0] src_m,
    input  logic [DATA_W-1:0] res_m,
    input  logic              wide,
    input  afu_fmode_e        mode,
    input  logic              carry_eff,
    input  logic              carry_in,
    output afu_flags_t        flags
);
    localparam logic [DATA_W-1:0] WIDE_MIN   = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] NARROW_MIN = DATA_W'(1) << (NARROW_W - 1);

    logic [DATA_W-1:0] mix;
    logic [DATA_W-1:0] min_neg;
    logic              top_mix;
    logic              top_res;
    logic              same;
    logic              parity_even;

    afu_parity #(.W(NARROW_W)) u_par (
        .vec  (res_m[NARROW_W-1:0]),
        .even (parity_even)
    );

    always_comb begin
        mix     = src_m ^ dst_m ^ res_m;
        top_mix = wide ? mix[DATA_W-1]   : mix[NARROW_W-1];
        top_res = wide ? res_m[DATA_W-1] : res_m[NARROW_W-1];
        min_neg = wide ? WIDE_MIN : NARROW_MIN;
        same    = (res_m == dst_m);

        flags    = '0;
        flags.af = mix[NIBBLE_BIT];
        flags.sf = top_res;
        flags.zf = (res_m == '0);
        flags.pf = parity_even;

        unique case (mode)
            FM_ADD: begin
                flags.cf = (res_m < dst_m) || (carry_eff && same);
                flags.of = !same && (flags.cf ^ top_mix);
            end
            FM_SUB: begin
                flags.cf = (res_m > dst_m) || (carry_eff && same);
                flags.of = !same && (flags.cf ^ top_mix);
            end
            FM_LOGIC: begin
                flags.af = 1'b0;
                flags.cf = 1'b0;
                flags.of = 1'b0;
            end
            FM_INC: begin
                flags.cf = carry_in;
                flags.of = (res_m == min_neg);
            end
            FM_DEC: begin
                flags.cf = carry_in;
                flags.of = (dst_m == min_neg);
            end
            default: begin
                flags.cf = 1'b0;
                flags.of = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import afu_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NARROW_W   = 8,
    parameter int NIBBLE_BIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              wide_i,
    input  logic [2:0]        op_i,
    input  logic              step_en_i,
    input  logic              step_dec_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              cf_o,
    output logic              af_o,
    output logic              of_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              pf_o
);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [DATA_W-1:0] STEP_ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr_en;
        afu_flags_t        flags;
    } stage_t;

    stage_t            stage_d, stage_q;
    logic              live_q;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] dst_m, src_m;
    logic [DATA_W-1:0] add_b, flag_src;
    logic              add_cin, add_sub, carry_eff, is_logic, wr_sel;
    afu_op_e           op_e;
    afu_fmode_e        fmode;
    logic [DATA_W-1:0] add_sum, logic_res, res_m;
    afu_flags_t        flags_n;

    // operand masking and operation decode
    always_comb begin
        mask      = wide_i ? '1 : NARROW_MASK;
        dst_m     = dst_i & mask;
        src_m     = src_i & mask;
        op_e      = afu_op_e'(op_i);
        add_b     = src_m;
        flag_src  = src_m;
        add_cin   = 1'b0;
        add_sub   = 1'b0;
        carry_eff = 1'b0;
        is_logic  = 1'b0;
        wr_sel    = 1'b1;
        fmode     = FM_ADD;
        if (step_en_i) begin
            add_b    = STEP_ONE;
            flag_src = STEP_ONE;
            add_sub  = step_dec_i;
            fmode    = step_dec_i ? FM_DEC : FM_INC;
        end else begin
            unique case (op_e)
                OP_ADC: begin
                    add_cin   = carry_i;
                    carry_eff = carry_i;
                end
                OP_SBB: begin
                    add_sub   = 1'b1;
                    add_cin   = carry_i;
                    carry_eff = carry_i;
                    fmode     = FM_SUB;
                end
                OP_SUB: begin
                    add_sub = 1'b1;
                    fmode   = FM_SUB;
                end
                OP_CMP: begin
                    add_sub = 1'b1;
                    fmode   = FM_SUB;
                    wr_sel  = 1'b0;
                end
                OP_OR, OP_AND, OP_XOR: begin
                    is_logic = 1'b1;
                    fmode    = FM_LOGIC;
                end
                default: ;
            endcase
        end
    end

    afu_addsub #(.W(DATA_W)) u_addsub (
        .a   (dst_m),
        .b   (add_b),
        .cin (add_cin),
        .sub (add_sub),
        .sum (add_sum)
    );

    afu_logic #(.W(DATA_W)) u_logic (
        .a   (dst_m),
        .b   (src_m),
        .op  (op_e),
        .res (logic_res)
    );

    assign res_m = (is_logic ? logic_res : add_sum) & mask;

    afu_flag_gen #(
        .DATA_W     (DATA_W),
        .NARROW_W   (NARROW_W),
        .NIBBLE_BIT (NIBBLE_BIT)
    ) u_flags (
        .dst_m     (dst_m),
        .src_m     (flag_src),
        .res_m     (res_m),
        .wide      (wide_i),
        .mode      (fmode),
        .carry_eff (carry_eff),
        .carry_in  (carry_i),
        .flags     (flags_n)
    );

    always_comb begin
        stage_d        = '0;
        stage_d.result = res_m;
        stage_d.wr_en  = wr_sel;
        stage_d.flags  = flags_n;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
            live_q  <= 1'b0;
        end else begin
            stage_q <= stage_d;
            live_q  <= 1'b1;
        end
    end

    assign result_o = stage_q.result;
    assign wr_en_o  = stage_q.wr_en;
    assign cf_o     = stage_q.flags.cf;
    assign af_o     = stage_q.flags.af;
    assign of_o     = stage_q.flags.of;
    assign sf_o     = stage_q.flags.sf;
    assign zf_o     = stage_q.flags.zf;
    assign pf_o     = stage_q.flags.pf;

    // R7
    cmp_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(!step_en_i && op_i == OP_CMP)) |-> !wr_en_o);

    // R6
    logic_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(!step_en_i && (op_i == OP_OR || op_i == OP_AND || op_i == OP_XOR)))
        |-> (!cf_o && !of_o && !af_o));

    // R8
    step_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(step_en_i)) |-> (cf_o == $past(carry_i)));

    // R2
    narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q && $past(!wide_i)) |-> (result_o[DATA_W-1:NARROW_W] == '0));

    // R9
    zero_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zf_o |-> (!sf_o && pf_o));

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] dst_i, src_i;
    logic        wide_i;
    logic [2:0]  op_i;
    logic        step_en_i, step_dec_i, carry_i;
    logic [15:0] result_o;
    logic        wr_en_o, cf_o, af_o, of_o, sf_o, zf_o, pf_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flag_alu u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .dst_i      (dst_i),
        .src_i      (src_i),
        .wide_i     (wide_i),
        .op_i       (op_i),
        .step_en_i  (step_en_i),
        .step_dec_i (step_dec_i),
        .carry_i    (carry_i),
        .result_o   (result_o),
        .wr_en_o    (wr_en_o),
        .cf_o       (cf_o),
        .af_o       (af_o),
        .of_o       (of_o),
        .sf_o       (sf_o),
        .zf_o       (zf_o),
        .pf_o       (pf_o)
    );

    function automatic int sx(input int v, input int wb);
        return (v >= (1 << (wb - 1))) ? v - (1 << wb) : v;
    endfunction

    function automatic logic [15:0] pick(input int i, input bit w);
        logic [15:0] v;
        case (i)
            0: v = 16'h0000;  1: v = 16'h0001;  2: v = 16'h0002;  3: v = 16'h000F;
            4: v = 16'h0010;  5: v = w ? 16'h7FFE : 16'h003C;
            6: v = w ? 16'h7FFF : 16'h0055;  7: v = w ? 16'h8000 : 16'h007E;
            8: v = w ? 16'h8001 : 16'h007F;  9: v = w ? 16'h00FF : 16'h0080;
            10: v = w ? 16'h0100 : 16'h0081; 11: v = w ? 16'h007F : 16'h00AA;
            12: v = w ? 16'h0080 : 16'h00C3; 13: v = w ? 16'hF0F0 : 16'h00F0;
            14: v = w ? 16'hFFFE : 16'h00FE; default: v = w ? 16'hFFFF : 16'h00FF;
        endcase
        return v;
    endfunction

    // apply one vector at a falling edge, check it at the next falling edge
    task automatic apply(input logic [15:0] d, input logic [15:0] s, input bit w,
                         input int op, input bit st, input bit sd, input bit c);
        int wb, m, dm, sm, ci, full, r, sres, half;
        bit ecf, eaf, eof, ewr, esf, ezf, epf, lg, bad;
        dst_i = d; src_i = s; wide_i = w; op_i = 3'(op);
        step_en_i = st; step_dec_i = sd; carry_i = c;
        wb = w ? 16 : 8;
        m = (1 << wb) - 1;
        half = 1 << (wb - 1);
        dm = int'(d) & m;
        sm = int'(s) & m;
        ewr = 1'b1; lg = 1'b0; ecf = 1'b0; eaf = 1'b0; eof = 1'b0; r = 0;
        if (st) begin
            if (!sd) begin
                r = (dm + 1) & m;
                eaf = ((dm & 15) + 1) > 15;
                eof = (r == half);
            end else begin
                r = (dm - 1) & m;
                eaf = ((dm & 15) == 0);
                eof = (dm == half);
            end
            ecf = c;
        end else begin
            case (op)
                0, 2: begin
                    ci = (op == 2) ? int'(c) : 0;
                    full = dm + sm + ci;
                    r = full & m;
                    ecf = full > m;
                    eaf = ((dm & 15) + (sm & 15) + ci) > 15;
                    sres = sx(dm, wb) + sx(sm, wb) + ci;
                    eof = (sres > half - 1) || (sres < -half);
                end
                3, 5, 7: begin
                    ci = (op == 3) ? int'(c) : 0;
                    full = dm - sm - ci;
                    r = full & m;
                    ecf = full < 0;
                    eaf = ((dm & 15) - (sm & 15) - ci) < 0;
                    sres = sx(dm, wb) - sx(sm, wb) - ci;
                    eof = (sres > half - 1) || (sres < -half);
                    ewr = (op != 7);
                end
                1: begin r = dm | sm; lg = 1'b1; end
                4: begin r = dm & sm; lg = 1'b1; end
                default: begin r = dm ^ sm; lg = 1'b1; end
            endcase
        end
        esf = ((r >> (wb - 1)) & 1) == 1;
        ezf = (r == 0);
        epf = ($countones(r & 255) % 2) == 0;

        @(negedge clk);
        n_vec++;
        bad = 1'b0;
        if (result_o !== 16'(r)) begin
            bad = 1'b1;
            $display("FAIL %s result d=%h s=%h op=%0d: actual %h expected %h",
                     w ? "R1" : "R2", d, s, op, result_o, 16'(r));
        end
        if (wr_en_o !== ewr) begin
            bad = 1'b1;
            $display("FAIL R7 wr_en op=%0d: actual %b expected %b", op, wr_en_o, ewr);
        end
        if (cf_o !== ecf) begin
            bad = 1'b1;
            $display("FAIL %s cf d=%h s=%h op=%0d c=%b: actual %b expected %b",
                     st ? "R8" : (lg ? "R6" : "R3"), d, s, op, c, cf_o, ecf);
        end
        if (af_o !== eaf) begin
            bad = 1'b1;
            $display("FAIL R4 af d=%h s=%h op=%0d: actual %b expected %b", d, s, op, af_o, eaf);
        end
        if (of_o !== eof) begin
            bad = 1'b1;
            $display("FAIL %s of d=%h s=%h op=%0d c=%b: actual %b expected %b",
                     st ? "R8" : (lg ? "R6" : "R5"), d, s, op, c, of_o, eof);
        end
        if ({sf_o, zf_o, pf_o} !== {esf, ezf, epf}) begin
            bad = 1'b1;
            $display("FAIL R9 sf/zf/pf r=%h: actual %b%b%b expected %b%b%b",
                     16'(r), sf_o, zf_o, pf_o, esf, ezf, epf);
        end
        if (bad) n_bad++;
    endtask

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0;
        dst_i = 16'hFFFF; src_i = 16'h0001; wide_i = 1'b1; op_i = 3'd0;
        step_en_i = 1'b0; step_dec_i = 1'b0; carry_i = 1'b1;
        repeat (3) @(negedge clk);
        // R10: outputs held at zero during reset
        n_vec++;
        if ({result_o, wr_en_o, cf_o, af_o, of_o, sf_o, zf_o, pf_o} !== 23'd0) begin
            n_bad++;
            $display("FAIL R10 reset outputs: actual %h expected 0",
                     {result_o, wr_en_o, cf_o, af_o, of_o, sf_o, zf_o, pf_o});
        end
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 R9: byte width sweep, upper bytes carry garbage
        for (int op = 0; op < 8; op++)
            for (int c = 0; c < 2; c++)
                for (int d = 0; d < 256; d++)
                    for (int k = 0; k < 16; k++)
                        apply(16'hA500 | 16'(d), 16'h5A00 | pick(k, 1'b0),
                              1'b0, op, 1'b0, 1'b0, c[0]);

        // R8: byte-width increment/decrement with the op code varied (ignored)
        for (int sd = 0; sd < 2; sd++)
            for (int c = 0; c < 2; c++)
                for (int d = 0; d < 256; d++)
                    apply(16'h3C00 | 16'(d), 16'hFFFF, 1'b0, d % 8, 1'b1, sd[0], c[0]);

        // R3 R5: word-width corners incl. 0x7FFF/0x8000 and 0xFFFF with carry-in
        for (int op = 0; op < 8; op++)
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < 16; i++)
                    for (int j = 0; j < 16; j++)
                        apply(pick(i, 1'b1), pick(j, 1'b1), 1'b1, op, 1'b0, 1'b0, c[0]);

        // R8: word-width steps across the corners
        for (int sd = 0; sd < 2; sd++)
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < 16; i++)
                    apply(pick(i, 1'b1), 16'h1234, 1'b1, 7 - i % 8, 1'b1, sd[0], c[0]);

        // R1 R2: pseudo-random mixed vectors
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 8000; n++) begin
            logic [15:0] d, s;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            d = lfsr[15:0];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s = lfsr[31:16] ^ lfsr[15:0];
            apply(d, s, lfsr[3], int'(lfsr[6:4]), lfsr[11:8] == 4'h0, lfsr[12], lfsr[13]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule